// File: doc/BRIEF.md
# ATA PIO cycle timing generator

This block sequences programmed-I/O bus cycles for four drives on two channels. The cycle has three phases: address setup, strobe active and recovery. Each phase length comes from a small set of timing bytes that the host writes through a byte-wide configuration port. For each drive, an address-timing byte carries a 2-bit setup code in its top bits. A read/write timing byte packs an active count and a recovery count, one in each nibble.

Drives 0 and 1 sit on the primary channel and each has its own pair of timing bytes. Drives 2 and 3 sit on the secondary channel and share one pair. Accesses to a drive's command-register block take their active and recovery counts from a separate command timing byte.

A request names the drive, the direction, and whether it is a command-block access. The block accepts the request only while idle. It then raises busy and address-valid, later pulses the read or write strobe, and drops busy when recovery ends. All phase lengths count in bus clocks. The timing is captured at acceptance.

Top module: `ata_pio_timer`

## Requirements
- R1: After a synchronous active-high reset, busy, addr_valid, rd_strobe and wr_strobe are low and every configuration byte reads back 0x00. A cycle run in this state has setup 4, active 16 and recovery 16 clocks.
- R2: The setup length comes from bits 7:6 of the drive's address-timing byte: 00 gives 4 clocks, 10 gives 3 clocks, 01 gives 2 clocks and 11 gives 5 clocks.
- R3: In the read/write timing byte, bits 7:4 hold the active count and bits 3:0 hold the recovery count. A nibble of 0 means 16 clocks.
- R4: The active phase is never shorter than 2 clocks, so an active nibble of 1 yields 2 clocks.
- R5: When the effective active count is above 3 and the recovery nibble is 1, recovery lasts 2 clocks.
- R6: When late_rev is high, recovery lasts one clock longer than R3 and R5 give.
- R7: The configuration select values are: 0 and 1 are drive 0's address-timing and read/write bytes, 2 and 3 are drive 1's, 4 and 5 are the shared secondary pair used by drives 2 and 3, and 6 is the command timing byte. Writes to select 7 are ignored and select 7 reads 0x00.
- R8: A command-block access (req_cmd high) takes its active and recovery counts from the command timing byte and its setup from the drive's address-timing byte. A command timing byte of 0x00 gives active 16 and recovery 16.
- R9: All 8 bits of the address-timing byte are stored and read back unchanged. Bits 5:0 have no effect on any phase length.
- R10: busy is high from the first setup clock through the last recovery clock. A request made while busy is high is ignored and starts no cycle.
- R11: addr_valid is high during setup and active and low during recovery. During active, rd_strobe is high for a read and wr_strobe is high for a write, and the two are never high together.
- R12: Phase lengths are captured when the request is accepted. A configuration write made during a cycle affects only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| late_rev | input | 1 | Adds one recovery clock (later silicon revision) |
| cfg_we | input | 1 | Configuration byte write enable |
| cfg_sel | input | 3 | Configuration byte select |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected configuration byte (combinational) |
| req | input | 1 | Cycle request, accepted when busy is low |
| req_drive | input | 2 | Target drive 0..3 |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_cmd | input | 1 | 1 = command-register block access |
| busy | output | 1 | Cycle in progress |
| addr_valid | output | 1 | Address driven (setup and active) |
| rd_strobe | output | 1 | Read strobe (active phase of a read) |
| wr_strobe | output | 1 | Write strobe (active phase of a write) |

## Verification
The assertions assume that req_write is stable for the clock in which a request is accepted. They also assume that late_rev changes only while the block is idle, because recovery length is fixed at acceptance. The bench drives every request and configuration write on the falling edge, for exactly one clock. It changes late_rev only between cycles, when busy is low. It measures each phase by counting the clocks of the addr_valid and strobe pattern, and compares those counts with values derived from the timing bytes it last wrote.

// File: rtl/ata_pio_timer.sv
module ata_pio_timer (
  input  logic       clk,
  input  logic       rst,
  input  logic       late_rev,
  input  logic       cfg_we,
  input  logic [2:0] cfg_sel,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       req,
  input  logic [1:0] req_drive,
  input  logic       req_write,
  input  logic       req_cmd,
  output logic       busy,
  output logic       addr_valid,
  output logic       rd_strobe,
  output logic       wr_strobe
);

  typedef enum logic [1:0] {IDLE, SETUP, ACT, REC} phase_t;

  logic [7:0] regs [0:7];
  phase_t     phase;
  logic [4:0] cnt, act_q, rec_q;
  logic       wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) regs[i] <= 8'h00;
    end else if (cfg_we && cfg_sel != 3'd7) begin
      regs[cfg_sel] <= cfg_wdata;
    end
  end

  assign cfg_rdata = regs[cfg_sel];

  logic [2:0] base;
  logic [7:0] at_byte, rw_byte;
  assign base    = req_drive[1] ? 3'd4 : {1'b0, req_drive[0], 1'b0};
  assign at_byte = regs[base];
  assign rw_byte = req_cmd ? regs[6] : regs[base | 3'd1];

  logic [4:0] setup_len, act_enc, act_len, rec_enc, rec_fix, rec_len;

  always_comb begin
    case (at_byte[7:6])
      2'b00:   setup_len = 5'd4;
      2'b10:   setup_len = 5'd3;
      2'b01:   setup_len = 5'd2;
      default: setup_len = 5'd5;
    endcase
  end

  assign act_enc = (rw_byte[7:4] == 4'd0) ? 5'd16 : {1'b0, rw_byte[7:4]};
  assign act_len = (act_enc == 5'd1) ? 5'd2 : act_enc;
  assign rec_enc = (rw_byte[3:0] == 4'd0) ? 5'd16 : {1'b0, rw_byte[3:0]};
  assign rec_fix = (act_len > 5'd3 && rec_enc == 5'd1) ? 5'd2 : rec_enc;
  assign rec_len = rec_fix + {4'd0, late_rev};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= IDLE;
      cnt   <= 5'd0;
      act_q <= 5'd0;
      rec_q <= 5'd0;
      wr_q  <= 1'b0;
    end else begin
      case (phase)
        IDLE: if (req) begin
          phase <= SETUP;
          cnt   <= setup_len - 5'd1;
          act_q <= act_len - 5'd1;
          rec_q <= rec_len - 5'd1;
          wr_q  <= req_write;
        end
        SETUP: if (cnt == 5'd0) begin
          phase <= ACT;
          cnt   <= act_q;
        end else cnt <= cnt - 5'd1;
        ACT: if (cnt == 5'd0) begin
          phase <= REC;
          cnt   <= rec_q;
        end else cnt <= cnt - 5'd1;
        default: if (cnt == 5'd0) phase <= IDLE;
                 else cnt <= cnt - 5'd1;
      endcase
    end
  end

  assign busy       = phase != IDLE;
  assign addr_valid = phase == SETUP || phase == ACT;
  assign rd_strobe  = phase == ACT && !wr_q;
  assign wr_strobe  = phase == ACT && wr_q;

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_strobe && wr_strobe));

  // R11
  strobe_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe || wr_strobe) |-> addr_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(addr_valid || rd_strobe || wr_strobe));

  // R10
  start_setup_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !busy) |=> (busy && addr_valid && !rd_strobe && !wr_strobe));

  // R11
  strobe_after_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_strobe || wr_strobe) |-> $past(addr_valid));

  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= 5'd16);

  // R11
  write_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !busy && req_write) |=> !rd_strobe);

endmodule

// File: tb/ata_pio_timer_test.sv
`timescale 1ns/1ps
module ata_pio_timer_test;
  logic clk = 0, rst = 1, late_rev = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic [7:0] cfg_rdata;
  logic req = 0, req_write = 0, req_cmd = 0;
  logic [1:0] req_drive = 0;
  logic busy, addr_valid, rd_strobe, wr_strobe;

  int tests = 0, fails = 0, cycles = 0;
  logic [7:0] sh [0:7];

  always #4 clk = ~clk;

  ata_pio_timer uut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int es(logic [1:0] c);
    case (c) 2'b00: return 4; 2'b10: return 3; 2'b01: return 2; default: return 5; endcase
  endfunction
  function automatic int ea(logic [3:0] n);
    int v = (n == 0) ? 16 : int'(n);
    return (v == 1) ? 2 : v;
  endfunction
  function automatic int er(logic [3:0] an, logic [3:0] rn, logic late);
    int v = (rn == 0) ? 16 : int'(rn);
    if (ea(an) > 3 && v == 1) v = 2;
    return v + int'(late);
  endfunction

  task automatic wcfg(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    if (s != 3'd7) sh[s] = d;
  endtask

  task automatic rcfg(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk); cfg_sel = s; #1 d = cfg_rdata;
  endtask

  // inj: 0 none, 1 request at sample inj_at, 2 config write at sample inj_at
  task automatic access(input logic [1:0] d, input logic w, input logic c,
                        input int inj, input int inj_at,
                        input logic [2:0] isel, input logic [7:0] idat,
                        output int s, output int a, output int r, output int bad);
    int n = 0;
    s = 0; a = 0; r = 0; bad = 0;
    @(negedge clk); req = 1; req_drive = d; req_write = w; req_cmd = c;
    @(negedge clk); req = 0;
    while (busy && n < 100) begin
      if (addr_valid && !rd_strobe && !wr_strobe) begin
        if (a > 0 || r > 0) bad++;
        s++;
      end else if (addr_valid && (rd_strobe || wr_strobe)) begin
        if (rd_strobe == w || wr_strobe != w || r > 0) bad++;
        a++;
      end else if (!addr_valid && !rd_strobe && !wr_strobe) r++;
      else bad++;
      if (n == inj_at && inj == 1) begin req = 1; req_drive = 2'd1; end
      if (n == inj_at && inj == 2) begin
        cfg_we = 1; cfg_sel = isel; cfg_wdata = idat; sh[isel] = idat;
      end
      #1;
      @(negedge clk);
      req = 0; cfg_we = 0;
      n++;
    end
    if (busy) bad++;
  endtask

  task automatic expect_run(input string tag, input logic [1:0] d, input logic w,
                            input logic c);
    int s, a, r, bad;
    logic [2:0] b;
    logic [7:0] rw;
    b = d[1] ? 3'd4 : {1'b0, d[0], 1'b0};
    rw = c ? sh[6] : sh[b | 3'd1];
    access(d, w, c, 0, -1, 3'd0, 8'd0, s, a, r, bad);
    chk({tag, " setup"}, s, es(sh[b][7:6]));
    chk({tag, " active"}, a, ea(rw[7:4]));
    chk({tag, " recovery"}, r, er(rw[7:4], rw[3:0], late_rev));
    chk({tag, " R11 phase order/strobe"}, bad, 0);
  endtask

  initial begin
    logic [7:0] v;
    int s, a, r, bad;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) sh[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 addr_valid", addr_valid, 0);
    chk("R1 strobes", rd_strobe | wr_strobe, 0);
    for (int i = 0; i < 8; i++) begin
      rcfg(i[2:0], v);
      chk("R1 reg reset", v, 0);
    end
    expect_run("R1 default drive0", 2'd0, 1'b0, 1'b0);
    expect_run("R1 default drive3", 2'd3, 1'b1, 1'b0);

    // R2 each setup code
    wcfg(3'd1, 8'h22);
    for (int c = 0; c < 4; c++) begin
      wcfg(3'd0, {c[1:0], 6'd0});
      expect_run("R2 setup code", 2'd0, 1'b0, 1'b0);
    end
    // R3 nibble decode
    wcfg(3'd1, 8'h5F); expect_run("R3 5/15", 2'd0, 1'b1, 1'b0);
    wcfg(3'd1, 8'h07); expect_run("R3 zero active", 2'd0, 1'b0, 1'b0);
    // R4 minimum active
    wcfg(3'd1, 8'h13); expect_run("R4 active 1", 2'd0, 1'b0, 1'b0);
    // R5 recovery stretch
    wcfg(3'd1, 8'h41); expect_run("R5 stretch", 2'd0, 1'b0, 1'b0);
    chk("R5 direct", er(4'h4, 4'h1, 1'b0), 2);
    wcfg(3'd1, 8'h31); expect_run("R5 no stretch", 2'd0, 1'b0, 1'b0);
    // R6 late revision
    @(negedge clk); late_rev = 1;
    wcfg(3'd1, 8'h41); expect_run("R6 late stretch", 2'd0, 1'b1, 1'b0);
    wcfg(3'd1, 8'h20); expect_run("R6 late 16", 2'd0, 1'b0, 1'b0);
    @(negedge clk); late_rev = 0;
    // R7 register selection
    wcfg(3'd0, 8'h40); wcfg(3'd1, 8'h23);
    wcfg(3'd2, 8'hC0); wcfg(3'd3, 8'h94);
    wcfg(3'd4, 8'h80); wcfg(3'd5, 8'h36);
    expect_run("R7 drive0", 2'd0, 1'b0, 1'b0);
    expect_run("R7 drive1", 2'd1, 1'b0, 1'b0);
    expect_run("R7 drive2", 2'd2, 1'b1, 1'b0);
    expect_run("R7 drive3 shared", 2'd3, 1'b0, 1'b0);
    wcfg(3'd7, 8'hFF); rcfg(3'd7, v); chk("R7 sel7 ignored", v, 0);
    // R8 command block
    expect_run("R8 cmd zero", 2'd1, 1'b0, 1'b1);
    wcfg(3'd6, 8'h32); expect_run("R8 cmd programmed", 2'd2, 1'b1, 1'b1);
    // R9 low bits carried, no timing effect
    wcfg(3'd0, 8'hBF); rcfg(3'd0, v); chk("R9 readback", v, 8'hBF);
    expect_run("R9 low bits", 2'd0, 1'b0, 1'b0);
    wcfg(3'd2, 8'h15); rcfg(3'd2, v); chk("R9 readback2", v, 8'h15);
    // R10 request while busy ignored
    wcfg(3'd0, 8'h00); wcfg(3'd1, 8'h22);
    access(2'd0, 1'b0, 1'b0, 1, 2, 3'd0, 8'd0, s, a, r, bad);
    chk("R10 busy length", s + a + r, 4 + 2 + 2);
    @(negedge clk); chk("R10 no extra cycle", busy, 0);
    @(negedge clk); chk("R10 still idle", busy, 0);
    // R12 config write during cycle
    access(2'd0, 1'b1, 1'b0, 2, 1, 3'd1, 8'h55, s, a, r, bad);
    chk("R12 active unchanged", a, 2);
    chk("R12 recovery unchanged", r, 2);
    expect_run("R12 next cycle", 2'd0, 1'b1, 1'b0);

    // random
    for (int k = 0; k < 40; k++) begin
      logic [2:0] rs = 3'($urandom_range(0, 6));
      wcfg(rs, 8'($urandom));
      @(negedge clk); late_rev = 1'($urandom);
      expect_run("R3 random", 2'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule